// File: doc/BRIEF.md
# Descriptor Ring Transfer Controller

This block drives a circular ring of transfer descriptors on behalf of a two-wire bus master. Software places descriptors in memory, programs a ring base address and a ring size, and then queues work by moving a head pointer inside the control register and setting the run bit. The controller consumes every slot from its own tail pointer up to the software head. For each slot it reads the four 32-bit descriptor words through a simple memory port and hands the descriptor to a transaction engine over a valid/done handshake. It then writes the result byte, the received and transmitted counts and the preserved retry byte back into the descriptor, advances the tail and raises interrupt flags.

Per-descriptor control bits decide whether a completion raises the done flag and whether an error halts the ring. The bit-level bus engine sits outside this block. The controller is a five-state machine:

- IDLE waits for work. IDLE->FETCH is taken when the run bit is set and head differs from tail.
- FETCH reads words 0 to 3. FETCH->EXEC follows the fourth acknowledged read.
- EXEC holds the engine request. EXEC->WRBACK follows the engine's done pulse.
- WRBACK writes the result word. WRBACK->ADVANCE follows the acknowledged write.
- ADVANCE moves the tail, sets the flags and may halt. ADVANCE->IDLE is always taken.

Top module: `smt_ring_ctrl`

## Requirements
- R1: After reset the control word, status word and size register read as zero, and `irq` is low.
- R2: The register map is as follows.
  - Offset 0 is control: head pointer in bits 23:16, error-interrupt enable in bit 4, run bit in bit 0.
  - Offset 1 is status: tail pointer in bits 23:16, done flag in bit 5, error flag in bit 4, busy in bit 0.
  - Offset 2 holds the ring base byte address.
  - Offset 3 holds the entry count minus one in bits 7:0.
  - Fields written to offsets 0, 2 and 3 read back unchanged.
- R3: When the run bit is set and head differs from tail, the controller reads the 16-byte descriptor at base + 16*tail and presents it to the engine.
  - Word 0 goes out unchanged on `eng_desc`. From bit 0 upward it holds target address with R/W, write length or command, read length, and control.
  - Words 3 and 2 go out together on `eng_dptr`.
  - While the run bit is clear, nothing is fetched.
- R4: After the engine's done pulse, descriptor word 1 is rewritten. From bit 0 upward it holds the engine status, the retry byte as read, the received count and the transmitted count.
- R5: After each write-back the tail advances by one, and it wraps to 0 after the value held in the size register.
- R6: The done flag is set only when the finished descriptor's control byte has bit 6 (0x40) set.
- R7: An error is any of status bits 7:2 (mask 0xFC). It sets the error flag only when the error-interrupt enable is set. `irq` is high exactly while either flag is set.
- R8: Writing 1 to status bit 5 or bit 4 clears that flag. Writing 0 leaves it unchanged.
- R9: A descriptor whose control byte has bit 7 (0x80) set and whose status carries an error clears the run bit and leaves the tail on that descriptor, so the ring halts.
- R10: Clearing the run bit during a transfer lets that descriptor finish, including write-back and tail advance, and then no further descriptor is fetched.
- R11: The busy bit is high from the first fetch until the tail update of that descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access accepted or completed |
| eng_valid | output | 1 | Descriptor offered to the transaction engine |
| eng_desc | output | 32 | Descriptor word 0 |
| eng_dptr | output | 64 | Descriptor data pointer |
| eng_done | input | 1 | Engine finished (single-cycle pulse) |
| eng_status | input | 8 | Engine result status byte |
| eng_rx | input | 8 | Bytes received |
| eng_tx | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state register shows at the ports within one transaction. It can show as a memory request at an address outside the current slot, as a write-back to the wrong word, or as a tail that does not step by one. The tail and status bytes are visible through the status register and the descriptor memory about a dozen cycles after queuing, so every descriptor is checked by reading both after it drains. A wrong halt or run-bit decision shows as a tail that moves past a failed stop-on-error slot, or as a second slot being fetched after the run bit was cleared. Both are visible in the following 30 cycles.

// File: rtl/smt_ring_pkg.sv
package smt_ring_pkg;
    localparam int PTR_W = 8;
    localparam int WORDS = 4;
    localparam int WIDX_W = $clog2(WORDS);

    // register word offsets
    localparam logic [1:0] RG_CTRL = 2'd0;
    localparam logic [1:0] RG_STAT = 2'd1;
    localparam logic [1:0] RG_BASE = 2'd2;
    localparam logic [1:0] RG_SIZE = 2'd3;

    // control-byte bits inside descriptor word 0 (byte 3)
    localparam int DW0_INT_BIT = 30;
    localparam int DW0_SOE_BIT = 31;

    // status byte: bits 7:2 denote errors
    localparam logic [7:0] ST_ERR_MASK = 8'hFC;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_EXEC,
        S_WRBACK,
        S_ADVANCE
    } ring_state_e;
endpackage

// File: rtl/smt_ring_tail.sv
module smt_ring_tail
    import smt_ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [PTR_W-1:0] size_m1,
    output logic [PTR_W-1:0] tail
);
    logic [PTR_W-1:0] tail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tail_q <= '0;
        else if (advance)
            tail_q <= (tail_q == size_m1) ? '0 : tail_q + 1'b1;
    end

    assign tail = tail_q;

    // R5: the tail only ever steps by one or wraps to zero
    a_r5_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q != $past(tail_q)) |-> (tail_q == $past(tail_q) + 1'b1 || tail_q == '0));
endmodule

// File: rtl/smt_ring_flags.sv
module smt_ring_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_err,
    input  logic err_en,
    input  logic clr_done,
    input  logic clr_err,
    output logic done_flag,
    output logic err_flag,
    output logic irq
);
    logic done_q, err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (set_done)              done_q <= 1'b1;
            else if (clr_done)         done_q <= 1'b0;
            if (set_err && err_en)     err_q  <= 1'b1;
            else if (clr_err)          err_q  <= 1'b0;
        end
    end

    assign done_flag = done_q;
    assign err_flag  = err_q;
    assign irq       = done_q | err_q;

    // R7: the error flag can only rise while error interrupts are enabled
    a_r7_err_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(err_en));
    // R8: a write-one clear with no simultaneous set empties the flag
    a_r8_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !set_done) |=> !done_q);
endmodule

// File: rtl/smt_ring_ctrl.sv
module smt_ring_ctrl
    import smt_ring_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              eng_valid,
    output logic [31:0]       eng_desc,
    output logic [63:0]       eng_dptr,
    input  logic              eng_done,
    input  logic [7:0]        eng_status,
    input  logic [7:0]        eng_rx,
    input  logic [7:0]        eng_tx,
    output logic              irq
);
    localparam int OFF_W = PTR_W + WIDX_W + 2;

    ring_state_e       state_q, state_d;
    logic              run_q, eie_q;
    logic [PTR_W-1:0]  head_q, size_q, tail;
    logic [ADDR_W-1:0] base_q;
    logic [WIDX_W-1:0] widx_q, word_sel;
    logic [31:0]       dw0_q, dw2_q, dw3_q;
    logic [7:0]        retry_q, res_st_q, res_rx_q, res_tx_q;
    logic              halt, advance, set_done, set_err, clr_done, clr_err;
    logic              done_flag, err_flag;
    logic [OFF_W-1:0]  offset;

    assign halt     = dw0_q[DW0_SOE_BIT] && |(res_st_q & ST_ERR_MASK);
    assign advance  = (state_q == S_ADVANCE) && !halt;
    assign set_done = (state_q == S_ADVANCE) && dw0_q[DW0_INT_BIT];
    assign set_err  = (state_q == S_ADVANCE) && |(res_st_q & ST_ERR_MASK);
    assign clr_done = reg_we && reg_addr == RG_STAT && reg_wdata[5];
    assign clr_err  = reg_we && reg_addr == RG_STAT && reg_wdata[4];

    smt_ring_tail u_tail (
        .clk(clk), .rst_n(rst_n), .advance(advance), .size_m1(size_q), .tail(tail)
    );

    smt_ring_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_done(set_done), .set_err(set_err),
        .err_en(eie_q), .clr_done(clr_done), .clr_err(clr_err),
        .done_flag(done_flag), .err_flag(err_flag), .irq(irq)
    );

    // software registers; a halt overrides a same-cycle run-bit write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            eie_q  <= 1'b0;
            head_q <= '0;
            base_q <= '0;
            size_q <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    RG_CTRL: begin
                        run_q  <= reg_wdata[0];
                        eie_q  <= reg_wdata[4];
                        head_q <= reg_wdata[23:16];
                    end
                    RG_BASE: base_q <= ADDR_W'(reg_wdata);
                    RG_SIZE: size_q <= reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (state_q == S_ADVANCE && halt)
                run_q <= 1'b0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (run_q && head_q != tail) state_d = S_FETCH;
            S_FETCH:   if (mem_ack && widx_q == WIDX_W'(WORDS - 1)) state_d = S_EXEC;
            S_EXEC:    if (eng_done) state_d = S_WRBACK;
            S_WRBACK:  if (mem_ack) state_d = S_ADVANCE;
            S_ADVANCE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and descriptor capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            widx_q   <= '0;
            dw0_q    <= '0;
            dw2_q    <= '0;
            dw3_q    <= '0;
            retry_q  <= '0;
            res_st_q <= '0;
            res_rx_q <= '0;
            res_tx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE)
                widx_q <= '0;
            if (state_q == S_FETCH && mem_ack) begin
                widx_q <= widx_q + 1'b1;
                unique case (widx_q)
                    2'd0: dw0_q   <= mem_rdata;
                    2'd1: retry_q <= mem_rdata[15:8];
                    2'd2: dw2_q   <= mem_rdata;
                    default: dw3_q <= mem_rdata;
                endcase
            end
            if (state_q == S_EXEC && eng_done) begin
                res_st_q <= eng_status;
                res_rx_q <= eng_rx;
                res_tx_q <= eng_tx;
            end
        end
    end

    // outputs
    always_comb begin
        word_sel  = (state_q == S_WRBACK) ? WIDX_W'(1) : widx_q;
        offset    = {tail, word_sel, 2'b00};
        mem_req   = (state_q == S_FETCH) || (state_q == S_WRBACK);
        mem_we    = (state_q == S_WRBACK);
        mem_addr  = base_q + ADDR_W'(offset);
        mem_wdata = {res_tx_q, res_rx_q, retry_q, res_st_q};
        eng_valid = (state_q == S_EXEC);
        eng_desc  = dw0_q;
        eng_dptr  = {dw3_q, dw2_q};
        unique case (reg_addr)
            RG_CTRL: reg_rdata = {8'h00, head_q, 11'h000, eie_q, 3'b000, run_q};
            RG_STAT: reg_rdata = {8'h00, tail, 10'h000, done_flag, err_flag, 3'b000,
                                  state_q != S_IDLE};
            RG_BASE: reg_rdata = 32'(base_q);
            default: reg_rdata = {24'h0, size_q};
        endcase
    end

    // R9: a halting descriptor leaves the run bit cleared
    a_r9_halt_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADVANCE && halt && !(reg_we && reg_addr == RG_CTRL && reg_wdata[0]))
        |=> !run_q);
    // R10: with the run bit clear an idle controller stays idle
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !run_q) |=> state_q == S_IDLE);
    // R4: a memory write happens only after an engine completion
    a_r4_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(eng_done));
endmodule

// File: tb/smt_ring_ctrl_tb.sv
module smt_ring_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam logic [31:0] BASE = 32'h100;
    localparam int NVEC = 6;
    // {control byte, engine status, rx count, tx count}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h40_01_03_02, 32'h00_01_00_05, 32'h40_08_00_01,
        32'h08_10_02_02, 32'h05_01_07_00, 32'h60_04_01_01};

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic eng_valid, eng_done = 1'b0, irq;
    logic [31:0] eng_desc, cap_desc = '0;
    logic [63:0] eng_dptr, cap_dptr = '0;
    logic [7:0] eng_status = '0, eng_rx = '0, eng_tx = '0;
    logic [1:0] ecnt = '0;
    logic [31:0] mem [256];
    logic host_we = 1'b0;
    logic [7:0] host_idx = '0;
    logic [31:0] host_data = '0;
    int checks = 0, fails = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smt_ring_ctrl #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .eng_valid(eng_valid),
        .eng_desc(eng_desc), .eng_dptr(eng_dptr), .eng_done(eng_done),
        .eng_status(eng_status), .eng_rx(eng_rx), .eng_tx(eng_tx), .irq(irq));

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (host_we) mem[host_idx] <= host_data;
        else if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (eng_valid && !eng_done) begin
            cap_desc <= eng_desc;
            cap_dptr <= eng_dptr;
            if (ecnt == 2'd2) begin eng_done <= 1'b1; ecnt <= '0; end
            else ecnt <= ecnt + 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
            $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic hw(input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_idx = idx; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [7:0] slot_idx(input int slot, input int w);
        return 8'((BASE >> 2) + slot * 4 + w);
    endfunction

    task automatic put_desc(input int slot, input logic [7:0] ctl);
        hw(slot_idx(slot, 0), {ctl, 8'h04, 8'h22, 8'hA1});
        hw(slot_idx(slot, 1), {8'hEE, 8'hDD, 8'h5A, 8'hCC});
        hw(slot_idx(slot, 2), 32'h1000_0000 + slot);
        hw(slot_idx(slot, 3), 32'h0000_00F0 + slot);
    endtask

    function automatic logic [31:0] ctrl_word(input int head, input bit run, input bit eie);
        return {8'h00, 8'(head), 11'h0, eie, 3'b000, run};
    endfunction

    initial begin
        logic [31:0] r;
        int tail_exp;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(RG_CTRL_A(), r); chk("R1 ctrl after reset", r, 0);
        rd(2'd1, r);        chk("R1 status after reset", r, 0);
        rd(2'd3, r);        chk("R1 size after reset", r, 0);
        chk("R1 irq after reset", irq, 0);

        // register map
        wr(2'd2, BASE);
        wr(2'd3, 32'd3);
        rd(2'd2, r); chk("R2 base readback", r, BASE);
        rd(2'd3, r); chk("R2 size readback", r, 3);
        wr(2'd0, ctrl_word(1, 0, 1));
        rd(2'd0, r); chk("R2 ctrl readback", r, ctrl_word(1, 0, 1));
        repeat (10) @(negedge clk);
        rd(2'd1, r); chk("R3 no fetch while run bit clear", r, 0);

        // vector table walk, ring of four entries
        tail_exp = 0;
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] ctl, st, rx, tx;
            bit eie, e_err;
            ctl = VEC[i][31:24]; st = VEC[i][23:16]; rx = VEC[i][15:8]; tx = VEC[i][7:0];
            eie = i[0];
            put_desc(tail_exp, ctl);
            eng_status = st; eng_rx = rx; eng_tx = tx;
            wr(2'd0, ctrl_word((tail_exp + 1) % 4, 1, eie));
            repeat (2) @(negedge clk);
            rd(2'd1, r); chk("R11 busy during transfer", r[0], 1);
            repeat (25) @(negedge clk);
            chk("R3 descriptor word0 to engine", cap_desc, {ctl, 8'h04, 8'h22, 8'hA1});
            chk("R3 data pointer to engine", cap_dptr,
                {32'h0000_00F0 + tail_exp, 32'h1000_0000 + tail_exp});
            chk("R4 write-back word", mem[slot_idx(tail_exp, 1)], {tx, rx, 8'h5A, st});
            tail_exp = (tail_exp + 1) % 4;
            e_err = |(st & 8'hFC) && eie;
            rd(2'd1, r);
            chk("R5 tail advance and wrap", r[23:16], tail_exp);
            chk("R11 busy clear after finish", r[0], 0);
            chk("R6 done flag", r[5], ctl[6]);
            chk("R7 error flag", r[4], e_err);
            chk("R7 irq", irq, ctl[6] | e_err);
            wr(2'd1, 32'h30);
            rd(2'd1, r); chk("R8 flags cleared by write one", r[5:4], 0);
        end

        // writing zeros to the flag bits leaves them set
        put_desc(tail_exp, 8'h40);
        eng_status = 8'h01;
        wr(2'd0, ctrl_word((tail_exp + 1) % 4, 1, 1));
        repeat (30) @(negedge clk);
        tail_exp = (tail_exp + 1) % 4;
        wr(2'd1, 32'h0);
        rd(2'd1, r); chk("R8 write zero keeps done flag", r[5], 1);
        wr(2'd1, 32'h30);

        // stop on error halts the ring with two slots pending
        put_desc(tail_exp, 8'hC0);
        eng_status = 8'h08;
        wr(2'd0, ctrl_word((tail_exp + 2) % 4, 1, 1));
        repeat (45) @(negedge clk);
        rd(2'd0, r); chk("R9 run bit cleared on halt", r[0], 0);
        rd(2'd1, r); chk("R9 tail held on failing slot", r[23:16], tail_exp);
        chk("R9 error flag on halt", r[4], 1);
        chk("R9 status written back", mem[slot_idx(tail_exp, 1)][7:0], 8'h08);
        wr(2'd1, 32'h30);

        // clearing the run bit mid-transfer
        put_desc(tail_exp, 8'h00);
        put_desc((tail_exp + 1) % 4, 8'h00);
        eng_status = 8'h01;
        wr(2'd0, ctrl_word((tail_exp + 2) % 4, 1, 0));
        repeat (5) @(negedge clk);
        wr(2'd0, ctrl_word((tail_exp + 2) % 4, 0, 0));
        repeat (40) @(negedge clk);
        rd(2'd1, r);
        chk("R10 in-flight slot completes", r[23:16], (tail_exp + 1) % 4);
        chk("R10 idle after stop", r[0], 0);
        chk("R10 next slot untouched", mem[slot_idx((tail_exp + 1) % 4, 1)], 32'hEEDD5ACC);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    function automatic logic [1:0] RG_CTRL_A();
        return 2'd0;
    endfunction
endmodule